// File: doc/BRIEF.md
# Programmable IR Carrier Generator

This block produces the modulated carrier for an infrared remote-control output pin. A 3-bit mode value written by the processor core picks one of seven period/duty combinations, counted in clock cycles, or a no-carrier mode in which the pin is a plain static output. A set/clear output latch gates the waveform. The pin is open-drain, so the block reports whether its pull-down transistor should conduct (`drive_en_o`) together with the internal carrier level (`level_o`).

The carrier always starts with its high phase. It starts when the latch is switched on, when a new mode is written, and when stop mode ends. While the latch is off, stop is asserted or the no-carrier mode is selected, the period counter is held at zero. Stop mode turns the transistor off but keeps the latch and mode, so the pin returns to its earlier behaviour once stop clears.

Top module: `ir_carrier_gen`

## Requirements
- R1: While reset is asserted and right after it, `drive_en_o` and `level_o` are 0, the output latch is off and the mode is 0.
- R2: With the latch on, stop low and a carrier mode selected, `level_o` is 1 for the first H cycles of each P-cycle period and 0 for the rest, with (P,H) = mode 0: (96,48), 1: (96,32), 2: (64,32), 3: (64,16), 4: (88,32), 6: (96,24), 7: (92,46).
- R3: Mode 5 produces no carrier: `level_o` stays 0 and `drive_en_o` equals the output latch while stop is low.
- R4: A `pin_set` pulse turns the output latch on and a `pin_clr` pulse turns it off, both from the next cycle; when both are pulsed in one cycle, clear wins.
- R5: While the latch is off, `drive_en_o` and `level_o` are 0; after the latch is set, the carrier begins with a full high phase.
- R6: A mode write (`mode_we` with `mode_wdata`) takes effect the next cycle and restarts the period at the start of the high phase, even in mid-period.
- R7: While `stop_i` is high, `drive_en_o` and `level_o` are 0. Latch and mode are kept, and the carrier restarts with a full high phase after stop clears.
- R8: In a carrier mode, `drive_en_o` equals `level_o`, so the transistor conducts exactly during the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wdata | input | 3 | Mode value to load |
| mode_we | input | 1 | Mode write strobe |
| pin_set | input | 1 | Set-output strobe for this pin |
| pin_clr | input | 1 | Clear-output strobe for this pin |
| stop_i | input | 1 | Stop-mode flag |
| drive_en_o | output | 1 | Open-drain transistor enable |
| level_o | output | 1 | Carrier level |

## Verification
Every carrier mode runs for more than two periods, so a wrong period length, a wrong high count or a low-first waveform shows as a mismatch against a behavioural model on the exact cycle it occurs. A mode write in mid-period tells a proper restart apart from a leftover count, and cycles with the latch off and stop pulses show whether the counter is held and restarts high. The no-carrier mode, driven with set, clear and both strobes together, separates plain-latch behaviour and clear priority from carrier gating.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;
  localparam int MODE_W = 3;
  localparam int CNT_W  = 7;
  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  localparam mode_t MODE_STATIC = 3'd5;

  function automatic cnt_t period_of(input mode_t m);
    case (m)
      3'd0, 3'd1, 3'd6: period_of = cnt_t'(96);
      3'd2, 3'd3:       period_of = cnt_t'(64);
      3'd4:             period_of = cnt_t'(88);
      3'd7:             period_of = cnt_t'(92);
      default:          period_of = cnt_t'(1);
    endcase
  endfunction

  function automatic cnt_t high_of(input mode_t m);
    case (m)
      3'd0:    high_of = cnt_t'(48);
      3'd1:    high_of = cnt_t'(32);
      3'd2:    high_of = cnt_t'(32);
      3'd3:    high_of = cnt_t'(16);
      3'd4:    high_of = cnt_t'(32);
      3'd6:    high_of = cnt_t'(24);
      3'd7:    high_of = cnt_t'(46);
      default: high_of = cnt_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/ir_mode_reg.sv
module ir_mode_reg
  import ir_carrier_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t wdata,
  input  logic  we,
  input  logic  set_i,
  input  logic  clr_i,
  output mode_t mode_q,
  output logic  latch_q
);
  mode_t mode_d;
  logic  latch_d;

  always_comb begin
    mode_d  = mode_q;
    latch_d = latch_q;
    if (we)         mode_d  = wdata;
    if (clr_i)      latch_d = 1'b0;
    else if (set_i) latch_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      latch_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      latch_q <= latch_d;
    end
  end

  assert_clr_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !latch_q);
  assert_set_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> latch_q);
endmodule

// File: rtl/ir_period_cnt.sv
module ir_period_cnt
  import ir_carrier_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  cnt_t period,
  input  cnt_t high_len,
  output logic phase_hi
);
  cnt_t cnt_q, cnt_d;
  logic wrap;

  assign wrap = (cnt_q == period - cnt_t'(1));

  always_comb begin
    if (restart || !run) cnt_d = '0;
    else if (wrap)       cnt_d = '0;
    else                 cnt_d = cnt_q + cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign phase_hi = (cnt_q < high_len);

  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < period));
  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  assert_idle_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_wdata,
  input  logic       mode_we,
  input  logic       pin_set,
  input  logic       pin_clr,
  input  logic       stop_i,
  output logic       drive_en_o,
  output logic       level_o
);
  mode_t mode_q;
  logic  latch_q, is_static, run, phase_hi, active;
  cnt_t  period, high_len;

  ir_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wdata(mode_wdata), .we(mode_we),
    .set_i(pin_set), .clr_i(pin_clr), .mode_q(mode_q), .latch_q(latch_q)
  );

  assign is_static = (mode_q == MODE_STATIC);
  assign active    = latch_q && !stop_i;
  assign run       = active && !is_static;
  assign period    = period_of(mode_q);
  assign high_len  = high_of(mode_q);

  ir_period_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(mode_we), .run(run),
    .period(period), .high_len(high_len), .phase_hi(phase_hi)
  );

  assign level_o    = run && phase_hi;
  assign drive_en_o = active && (is_static || phase_hi);

  assert_stop_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> (!drive_en_o && !level_o));
  assert_static_nolevel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_static |-> !level_o);
  assert_latch_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q |-> !drive_en_o);
  assert_drive_eq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !is_static |-> (drive_en_o == level_o));
endmodule

// File: tb/ir_carrier_gen_test.sv
`timescale 1ns/1ps
module ir_carrier_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_wdata = '0;
  logic mode_we = 1'b0, pin_set = 1'b0, pin_clr = 1'b0, stop_i = 1'b0;
  logic drive_en_o, level_o;

  int checks = 0, errors = 0;
  int m_mode = 0, m_cnt = 0;
  bit m_latch = 0;

  always #2.5 clk = ~clk;

  ir_carrier_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_wdata(mode_wdata), .mode_we(mode_we),
    .pin_set(pin_set), .pin_clr(pin_clr), .stop_i(stop_i),
    .drive_en_o(drive_en_o), .level_o(level_o)
  );

  function automatic int per(int m);
    case (m) 0: return 96; 1: return 96; 2: return 64; 3: return 64;
      4: return 88; 6: return 96; 7: return 92; default: return 1; endcase
  endfunction
  function automatic int hi(int m);
    case (m) 0: return 48; 1: return 32; 2: return 32; 3: return 16;
      4: return 32; 6: return 24; 7: return 46; default: return 0; endcase
  endfunction

  task automatic check(string tag);
    bit exp_lvl, exp_drv, on;
    on = m_latch && !stop_i;
    exp_lvl = on && (m_mode != 5) && (m_cnt < hi(m_mode));
    exp_drv = on && ((m_mode == 5) || (m_cnt < hi(m_mode)));
    checks++;
    if (drive_en_o !== exp_drv || level_o !== exp_lvl) begin
      errors++;
      $display("FAIL %s: drive_en=%0b level=%0b, expected drive_en=%0b level=%0b",
               tag, drive_en_o, level_o, exp_drv, exp_lvl);
    end
  endtask

  task automatic cyc(string tag);
    bit run;
    @(posedge clk);
    run = m_latch && !stop_i && (m_mode != 5);
    if (mode_we || !run) m_cnt = 0;
    else if (m_cnt == per(m_mode) - 1) m_cnt = 0;
    else m_cnt++;
    if (mode_we) m_mode = mode_wdata;
    if (pin_clr) m_latch = 0;
    else if (pin_set) m_latch = 1;
    @(negedge clk);
    mode_we = 0; pin_set = 0; pin_clr = 0;
    check(tag);
  endtask

  task automatic run_n(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic wr_mode(int m, string tag);
    mode_wdata = 3'(m); mode_we = 1; cyc(tag);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset");
    run_n(5, "R1 idle");
    pin_set = 1; cyc("R4 set");
    run_n(200, "R8 mode0 default");
    for (int m = 0; m < 8; m++) begin
      if (m != 5) begin
        wr_mode(m, "R2 write");
        run_n(2 * per(m) + 5, "R2 carrier");
      end
    end
    wr_mode(0, "R6 write");
    run_n(30, "R6 pre");
    wr_mode(2, "R6 mid-period");
    run_n(80, "R6 restart");
    wr_mode(5, "R3 write");
    run_n(10, "R3 static on");
    pin_clr = 1; cyc("R4 clear");
    run_n(5, "R3 static off");
    pin_set = 1; pin_clr = 1; cyc("R4 both");
    run_n(3, "R4 clear wins");
    pin_set = 1; cyc("R4 set again");
    stop_i = 1; run_n(5, "R7 static stop");
    stop_i = 0; run_n(5, "R7 static resume");
    wr_mode(1, "R5 write");
    run_n(20, "R5 running");
    pin_clr = 1; cyc("R5 clear");
    run_n(20, "R5 held");
    pin_set = 1; cyc("R5 set");
    run_n(110, "R5 restart");
    wr_mode(3, "R7 write");
    run_n(10, "R7 pre");
    stop_i = 1; run_n(20, "R7 stopped");
    stop_i = 0; run_n(80, "R7 resume");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule